// File: doc/BRIEF.md
# Four-Way Set-Associative Data Cache Controller

This block sits between a processor's load/store path and a word-wide memory port. It holds a 4 KB data cache organised as four ways of 32 sets, each with a 32-byte line of eight 32-bit words. Read misses allocate: the controller picks a victim way, writes the victim back if it is dirty, then fetches the new line one word at a time in ascending order. Writes never allocate. Each write carries its own attribute. A write-back write that hits marks the line dirty. A write-through write, and any write that misses, also goes to memory.

Victim choice follows a control input. It is either a round-robin pointer or a two-bit slice of a free-running LFSR. From that starting way, the first unlocked way in ascending order, with wrap-around, is taken. A per-way lock mask keeps ways out of replacement. When every way is locked, way 0 is replaced anyway. Two maintenance operations act on the line that holds an address. Invalidate discards the line. Clean writes a dirty line to memory and keeps it valid. With the cache disabled, reads and writes bypass the array entirely.

Top module: `cache_ctrl`

## Requirements
- R1: A read hit returns the cached word with `cpu_hit`=1 and no memory traffic. A read miss fetches the eight words of the line at ascending addresses, returns the addressed word with `cpu_hit`=0, and later reads of that line hit.
- R2: A write miss performs one memory write of the word at `cpu_addr` and does not allocate, so a later read of that address misses.
- R3: A write hit with `cpu_wb`=1 updates only the cached word and marks the line dirty. A write hit with `cpu_wb`=0 updates the cached word and also writes memory.
- R4: In round-robin mode the pointer starts at way 0 after reset. It advances to the way after the one just filled, and only when a line is filled.
- R5: A way whose `lock_mask` bit is set is never filled unless all ways are locked. In random mode the start way is LFSR bits [1:0], and locked ways are skipped.
- R6: When all four lock bits are set, a read miss replaces way 0.
- R7: A dirty victim's eight words are written to memory before the new line is fetched.
- R8: With `cache_en`=0, reads and writes go to memory as single-word accesses and report `cpu_hit`=0. Tag matches are ignored and the array contents are left unchanged.
- R9: Invalidate clears the valid bit of the matching line without writing it to memory, and reports `cpu_hit`=1 if a line matched.
- R10: Clean writes a dirty matching line to memory and clears its dirty bit, leaving it valid. Cleaning a clean line causes no memory traffic.
- R11: `mem_req` stays high with `mem_addr` and `mem_wdata` stable until the cycle in which `mem_ack` is seen. Each acknowledged cycle moves one word.
- R12: `cpu_op` encodes read=0, write=1, invalidate=2 and clean=3. The address splits into tag [31:10], set [9:5], word [4:2] and byte [1:0]. The result is signalled by a one-cycle `cpu_ready` pulse, with `cpu_hit` and `cpu_rdata` valid in that cycle. After reset `cpu_ready` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_en | input | 1 | Cache enable; 0 bypasses the array |
| repl_random | input | 1 | 1 selects LFSR victim choice, 0 round-robin |
| lock_mask | input | 4 | Per-way replacement lock |
| cpu_req | input | 1 | Request strobe, accepted when idle |
| cpu_op | input | 2 | Operation code |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_wb | input | 1 | Write attribute: 1 write-back, 0 write-through |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Lookup hit flag, valid with cpu_ready |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one per word |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |

## Verification
A wrong tag, valid or dirty bit stays hidden until the same set is touched again. It then shows up as a wrong hit flag on the next access to the address, or as eight write beats that are missing or extra when the line is cleaned or evicted. A wrong replacement pointer or a broken lock mask shows up several misses later, when a line that should have survived reports a miss. For that reason the stimulus refills single sets in counted sequences, so each prediction falls due within a few operations. Stale data after a bypass or invalidate is visible in the very next read response.

// File: rtl/cache_pkg.sv
package cache_pkg;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int WAYS       = 4;
    localparam int SETS       = 32;
    localparam int LINE_WORDS = 8;
    localparam int LFSR_W     = 8;

    localparam int WAY_W  = $clog2(WAYS);
    localparam int SET_W  = $clog2(SETS);
    localparam int WRD_W  = $clog2(LINE_WORDS);
    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int TAG_W  = ADDR_W - SET_W - WRD_W - BYTE_W;
    localparam int IDX_W  = WAY_W + SET_W + WRD_W;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_INVAL = 2'd2,
        OP_CLEAN = 2'd3
    } cache_op_e;

    typedef enum logic [2:0] {
        TC_NOP, TC_ALLOC, TC_DIRTY, TC_CLEAN, TC_INVAL
    } tag_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOOK, ST_WBACK, ST_FILL, ST_WORD, ST_RESP
    } ctrl_state_e;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [SET_W-1:0]  set;
        logic [WRD_W-1:0]  word;
        logic [BYTE_W-1:0] byte_off;
    } addr_fields_t;

    typedef struct packed {
        cache_op_e         op;
        addr_fields_t      addr;
        logic [DATA_W-1:0] wdata;
        logic              wb;
    } cache_req_t;

    // Fibonacci LFSR, polynomial x^8 + x^6 + x^5 + x^4 + 1
    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store
    import cache_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] set_idx,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [WAY_W-1:0] sel_way,
    input  tag_cmd_e         cmd,
    input  logic [WAY_W-1:0] cmd_way,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    output logic [WAYS-1:0]  valid_vec,
    output logic [WAYS-1:0]  dirty_vec,
    output logic [TAG_W-1:0] sel_tag
);
    logic [WAYS-1:0][TAG_W-1:0] way_tag;
    logic [WAYS-1:0]            match;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0] tags [SETS];
        logic [SETS-1:0]  vld;
        logic [SETS-1:0]  drt;
        logic             this_way;

        assign this_way = (cmd_way == WAY_W'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                vld <= '0;
                drt <= '0;
            end else if (this_way) begin
                case (cmd)
                    TC_ALLOC: begin vld[set_idx] <= 1'b1; drt[set_idx] <= 1'b0; end
                    TC_DIRTY: drt[set_idx] <= 1'b1;
                    TC_CLEAN: drt[set_idx] <= 1'b0;
                    TC_INVAL: begin vld[set_idx] <= 1'b0; drt[set_idx] <= 1'b0; end
                    default: ;
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (this_way && cmd == TC_ALLOC) tags[set_idx] <= req_tag;
        end

        assign way_tag[w]   = tags[set_idx];
        assign valid_vec[w] = vld[set_idx];
        assign dirty_vec[w] = drt[set_idx];
        assign match[w]     = vld[set_idx] && (tags[set_idx] == req_tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit     = |match;
    assign sel_tag = way_tag[sel_way];
endmodule

// File: rtl/cache_data_ram.sv
module cache_data_ram
    import cache_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = WAYS * SETS * LINE_WORDS;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel
    import cache_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             random_mode,
    input  logic [WAYS-1:0]  lock_mask,
    input  logic             alloc,
    input  logic [WAY_W-1:0] alloc_way,
    output logic [WAY_W-1:0] victim
);
    logic [LFSR_W-1:0] lfsr_q;
    logic [WAY_W-1:0]  rr_q;
    logic [WAY_W-1:0]  start;
    logic [WAY_W-1:0]  idx;
    logic              found;

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr_q <= LFSR_W'(1);
            rr_q   <= '0;
        end else begin
            lfsr_q <= lfsr_next(lfsr_q);
            if (alloc) rr_q <= alloc_way + WAY_W'(1);
        end
    end

    // first unlocked way from the start point; way 0 if all are locked
    always_comb begin
        start  = random_mode ? lfsr_q[WAY_W-1:0] : rr_q;
        victim = '0;
        found  = 1'b0;
        idx    = '0;
        for (int k = 0; k < WAYS; k++) begin
            idx = start + WAY_W'(k);
            if (!found && !lock_mask[idx]) begin
                victim = idx;
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
    import cache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cache_en,
    input  logic              repl_random,
    input  logic [WAYS-1:0]   lock_mask,
    input  logic              cpu_req,
    input  logic [1:0]        cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_wb,
    output logic              cpu_ready,
    output logic              cpu_hit,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam logic [WRD_W-1:0] LAST_WORD = WRD_W'(LINE_WORDS - 1);

    ctrl_state_e       state;
    cache_req_t        req_q;
    cache_op_e         cur_op;
    logic [WRD_W-1:0]  cnt;
    logic [WAY_W-1:0]  sel_way;
    logic [DATA_W-1:0] rdata_q;
    logic              hit_q;

    logic              hit, en_hit, alloc;
    logic [WAY_W-1:0]  hit_way, victim, tway, ram_wway;
    logic [WAYS-1:0]   valid_vec, dirty_vec;
    logic [TAG_W-1:0]  sel_tag;
    tag_cmd_e          tcmd;
    logic              ram_we;
    logic [WRD_W-1:0]  ram_wword;
    logic [DATA_W-1:0] ram_wdata, ram_rdata;
    logic [IDX_W-1:0]  ram_raddr;

    assign cur_op = req_q.op;
    assign en_hit = hit && cache_en;

    cache_tag_store u_tags (
        .clk(clk), .rst(rst), .set_idx(req_q.addr.set), .req_tag(req_q.addr.tag),
        .sel_way(sel_way), .cmd(tcmd), .cmd_way(tway), .hit(hit), .hit_way(hit_way),
        .valid_vec(valid_vec), .dirty_vec(dirty_vec), .sel_tag(sel_tag)
    );

    assign ram_raddr = (state == ST_WBACK) ? {sel_way, req_q.addr.set, cnt}
                                           : {hit_way, req_q.addr.set, req_q.addr.word};

    cache_data_ram u_data (
        .clk(clk), .we(ram_we), .waddr({ram_wway, req_q.addr.set, ram_wword}),
        .wdata(ram_wdata), .raddr(ram_raddr), .rdata(ram_rdata)
    );

    cache_victim_sel u_victim (
        .clk(clk), .rst(rst), .random_mode(repl_random), .lock_mask(lock_mask),
        .alloc(alloc), .alloc_way(sel_way), .victim(victim)
    );

    // array and tag updates
    always_comb begin
        tcmd      = TC_NOP;
        tway      = sel_way;
        ram_we    = 1'b0;
        ram_wway  = sel_way;
        ram_wword = cnt;
        ram_wdata = mem_rdata;
        alloc     = 1'b0;
        case (state)
            ST_LOOK: begin
                if (cur_op == OP_WRITE && en_hit) begin
                    ram_we    = 1'b1;
                    ram_wway  = hit_way;
                    ram_wword = req_q.addr.word;
                    ram_wdata = req_q.wdata;
                    if (req_q.wb) begin
                        tcmd = TC_DIRTY;
                        tway = hit_way;
                    end
                end else if (cur_op == OP_INVAL && hit) begin
                    tcmd = TC_INVAL;
                    tway = hit_way;
                end
            end
            ST_WBACK: begin
                if (mem_ack && cnt == LAST_WORD && cur_op == OP_CLEAN) tcmd = TC_CLEAN;
            end
            ST_FILL: begin
                if (mem_ack) begin
                    ram_we = 1'b1;
                    if (cnt == LAST_WORD) begin
                        tcmd  = TC_ALLOC;
                        alloc = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            req_q   <= '0;
            cnt     <= '0;
            sel_way <= '0;
            rdata_q <= '0;
            hit_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (cpu_req) begin
                    req_q <= '{op: cache_op_e'(cpu_op), addr: addr_fields_t'(cpu_addr),
                               wdata: cpu_wdata, wb: cpu_wb};
                    cnt   <= '0;
                    state <= ST_LOOK;
                end
                ST_LOOK: begin
                    hit_q <= (cur_op == OP_READ || cur_op == OP_WRITE) ? en_hit : hit;
                    case (cur_op)
                        OP_READ: begin
                            if (en_hit) begin
                                rdata_q <= ram_rdata;
                                state   <= ST_RESP;
                            end else if (!cache_en) begin
                                state <= ST_WORD;
                            end else begin
                                sel_way <= victim;
                                state   <= (valid_vec[victim] && dirty_vec[victim]) ? ST_WBACK : ST_FILL;
                            end
                        end
                        OP_WRITE: state <= (en_hit && req_q.wb) ? ST_RESP : ST_WORD;
                        OP_CLEAN: begin
                            if (hit && dirty_vec[hit_way]) begin
                                sel_way <= hit_way;
                                state   <= ST_WBACK;
                            end else begin
                                state <= ST_RESP;
                            end
                        end
                        default: state <= ST_RESP;
                    endcase
                end
                ST_WBACK: if (mem_ack) begin
                    cnt <= cnt + WRD_W'(1);
                    if (cnt == LAST_WORD) state <= (cur_op == OP_CLEAN) ? ST_RESP : ST_FILL;
                end
                ST_FILL: if (mem_ack) begin
                    cnt <= cnt + WRD_W'(1);
                    if (cnt == req_q.addr.word) rdata_q <= mem_rdata;
                    if (cnt == LAST_WORD) state <= ST_RESP;
                end
                ST_WORD: if (mem_ack) begin
                    rdata_q <= mem_rdata;
                    state   <= ST_RESP;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = (state == ST_WBACK) || (state == ST_FILL) || (state == ST_WORD);
        mem_we    = (state == ST_WBACK) || (state == ST_WORD && cur_op == OP_WRITE);
        mem_wdata = (state == ST_WBACK) ? ram_rdata : req_q.wdata;
        case (state)
            ST_WBACK: mem_addr = {sel_tag, req_q.addr.set, cnt, BYTE_W'(0)};
            ST_FILL:  mem_addr = {req_q.addr.tag, req_q.addr.set, cnt, BYTE_W'(0)};
            default:  mem_addr = req_q.addr;
        endcase
    end

    assign cpu_ready = (state == ST_RESP);
    assign cpu_hit   = hit_q;
    assign cpu_rdata = rdata_q;
endmodule

// File: rtl/cache_ctrl_chk.sv
module cache_ctrl_chk
    import cache_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input ctrl_state_e       state,
    input cache_op_e         op,
    input logic              cache_en,
    input logic [WAYS-1:0]   lock_mask,
    input tag_cmd_e          tcmd,
    input logic [WAY_W-1:0]  tway
);
    // R12
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

    // R2
    write_noalloc_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOOK && op == OP_WRITE) |=> (state != ST_FILL));

    // R8
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOOK && !cache_en && (op == OP_READ || op == OP_WRITE))
        |=> (state != ST_FILL && state != ST_WBACK));

    // R5
    lock_respect_chk: assert property (@(posedge clk) disable iff (rst)
        (tcmd == TC_ALLOC && !(&lock_mask)) |-> !lock_mask[tway]);

    // R6
    all_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (tcmd == TC_ALLOC && (&lock_mask)) |-> (tway == '0));
endmodule

bind cache_ctrl cache_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .state(state), .op(cur_op),
    .cache_en(cache_en), .lock_mask(lock_mask), .tcmd(tcmd), .tway(tway)
);

// File: tb/cache_ctrl_bench.sv
module cache_ctrl_bench;
    import cache_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cache_en = 1'b1;
    logic              repl_random = 1'b0;
    logic [WAYS-1:0]   lock_mask = '0;
    logic              cpu_req = 1'b0;
    logic [1:0]        cpu_op = 2'd0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic              cpu_wb = 1'b0;
    logic              cpu_ready, cpu_hit, mem_req, mem_we;
    logic [DATA_W-1:0] cpu_rdata, mem_wdata;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_ack = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;

    always #10 clk = ~clk;

    cache_ctrl u_cache_ctrl (
        .clk(clk), .rst(rst), .cache_en(cache_en), .repl_random(repl_random),
        .lock_mask(lock_mask), .cpu_req(cpu_req), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_wb(cpu_wb), .cpu_ready(cpu_ready), .cpu_hit(cpu_hit),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int total = 0;
    int bad = 0;
    int wr_beats = 0;
    logic [DATA_W-1:0] bmem [4096];
    logic [ADDR_W-1:0] lat_addr = '0;

    function automatic logic [31:0] memval(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, a[15:0]};
    endfunction

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    // memory model: one acknowledge per requested word, alternate cycles
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                mem_ack  <= 1'b1;
                lat_addr <= mem_addr;
                if (mem_we) begin
                    bmem[mem_addr[13:2]] = mem_wdata;
                    wr_beats = wr_beats + 1;
                end else begin
                    mem_rdata <= bmem[mem_addr[13:2]];
                end
            end
        end
    end

    // scoreboard
    logic [31:0] q_data[$];
    bit          q_hit[$];
    bit          q_cd[$];
    bit          q_ch[$];
    string       q_req[$];
    logic        prev_ready = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            // R11: address on the acknowledged beat equals the address requested
            if (mem_ack) chk("R11", mem_addr, lat_addr);
            // R12: ready is a single-cycle pulse
            if (cpu_ready && prev_ready) chk("R12", 32'd1, 32'd0);
            if (cpu_ready && q_data.size() > 0) begin
                logic [31:0] ed;
                bit eh, cd, ch;
                string r;
                ed = q_data.pop_front();
                eh = q_hit.pop_front();
                cd = q_cd.pop_front();
                ch = q_ch.pop_front();
                r  = q_req.pop_front();
                if (ch) chk(r, {31'd0, cpu_hit}, {31'd0, eh});
                if (cd) chk(r, cpu_rdata, ed);
            end
            prev_ready = cpu_ready;
        end
    end

    task automatic issue(input logic [1:0] o, input logic [31:0] a, input logic [31:0] wd,
                         input bit wb, input logic [31:0] ed, input bit eh,
                         input bit cd, input bit ch, input string r);
        q_data.push_back(ed);
        q_hit.push_back(eh);
        q_cd.push_back(cd);
        q_ch.push_back(ch);
        q_req.push_back(r);
        @(negedge clk);
        cpu_req = 1'b1; cpu_op = o; cpu_addr = a; cpu_wdata = wd; cpu_wb = wb;
        @(negedge clk);
        cpu_req = 1'b0;
        while (!cpu_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [31:0] a, input bit eh, input string r);
        issue(2'd0, a, 32'd0, 1'b0, bmem[a[13:2]], eh, 1'b1, 1'b1, r);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int b0;
        for (int i = 0; i < 4096; i++) bmem[i] = memval(32'(i * 4));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12", {31'd0, cpu_ready}, 32'd0);
        chk("R11", {31'd0, mem_req}, 32'd0);

        // R1 miss then hit
        rd(32'h004, 1'b0, "R1");
        rd(32'h008, 1'b1, "R1");
        // R3 write-back hit: no memory write
        b0 = wr_beats;
        issue(2'd1, 32'h008, 32'hAAAA0008, 1'b1, 32'd0, 1'b1, 1'b0, 1'b1, "R3");
        chk("R3", 32'(wr_beats - b0), 32'd0);
        chk("R3", bmem[2], memval(32'h008));
        issue(2'd0, 32'h008, 32'd0, 1'b0, 32'hAAAA0008, 1'b1, 1'b1, 1'b1, "R3");
        // R3 write-through hit
        b0 = wr_beats;
        issue(2'd1, 32'h00C, 32'hBBBB000C, 1'b0, 32'd0, 1'b1, 1'b0, 1'b1, "R3");
        chk("R3", 32'(wr_beats - b0), 32'd1);
        chk("R3", bmem[3], 32'hBBBB000C);
        issue(2'd0, 32'h00C, 32'd0, 1'b0, 32'hBBBB000C, 1'b1, 1'b1, 1'b1, "R3");
        // R2 write miss, no allocation
        issue(2'd1, 32'h2000, 32'hCCCC2000, 1'b1, 32'd0, 1'b0, 1'b0, 1'b1, "R2");
        chk("R2", bmem[32'h2000 >> 2], 32'hCCCC2000);
        rd(32'h2000, 1'b0, "R2");
        // fill the remaining ways of set 0 (R4 round-robin)
        rd(32'h400, 1'b0, "R4");
        rd(32'h800, 1'b0, "R4");
        // R7 dirty way 0 evicted by the fifth line
        b0 = wr_beats;
        rd(32'hC00, 1'b0, "R7");
        chk("R7", 32'(wr_beats - b0), 32'd8);
        chk("R7", bmem[2], 32'hAAAA0008);
        rd(32'h400, 1'b1, "R4");
        rd(32'h800, 1'b1, "R4");
        rd(32'hC00, 1'b1, "R4");
        rd(32'h004, 1'b0, "R4");
        // R5 lock way 2 (holds 0x400)
        lock_mask = 4'b0100;
        rd(32'h1400, 1'b0, "R5");
        rd(32'h1800, 1'b0, "R5");
        rd(32'h1C00, 1'b0, "R5");
        rd(32'h2400, 1'b0, "R5");
        rd(32'h400, 1'b1, "R5");
        rd(32'h1800, 1'b1, "R4");
        // R6 all locked: way 0 (0x1800) replaced
        lock_mask = 4'b1111;
        rd(32'h2800, 1'b0, "R6");
        rd(32'h1C00, 1'b1, "R6");
        rd(32'h400, 1'b1, "R6");
        rd(32'h2400, 1'b1, "R6");
        rd(32'h1800, 1'b0, "R6");
        // R8 bypass
        issue(2'd1, 32'h404, 32'hDDDD0404, 1'b1, 32'd0, 1'b1, 1'b0, 1'b1, "R8");
        cache_en = 1'b0;
        rd(32'h404, 1'b0, "R8");
        issue(2'd1, 32'h404, 32'hEEEE0404, 1'b1, 32'd0, 1'b0, 1'b0, 1'b1, "R8");
        chk("R8", bmem[32'h404 >> 2], 32'hEEEE0404);
        cache_en = 1'b1;
        issue(2'd0, 32'h404, 32'd0, 1'b0, 32'hDDDD0404, 1'b1, 1'b1, 1'b1, "R8");
        // R10 clean
        b0 = wr_beats;
        issue(2'd3, 32'h404, 32'd0, 1'b0, 32'd0, 1'b1, 1'b0, 1'b1, "R10");
        chk("R10", 32'(wr_beats - b0), 32'd8);
        chk("R10", bmem[32'h404 >> 2], 32'hDDDD0404);
        bmem[32'h404 >> 2] = 32'h12340404;
        b0 = wr_beats;
        issue(2'd3, 32'h404, 32'd0, 1'b0, 32'd0, 1'b1, 1'b0, 1'b1, "R10");
        chk("R10", 32'(wr_beats - b0), 32'd0);
        chk("R10", bmem[32'h404 >> 2], 32'h12340404);
        issue(2'd0, 32'h404, 32'd0, 1'b0, 32'hDDDD0404, 1'b1, 1'b1, 1'b1, "R10");
        // R9 invalidate
        b0 = wr_beats;
        issue(2'd2, 32'h404, 32'd0, 1'b0, 32'd0, 1'b1, 1'b0, 1'b1, "R9");
        chk("R9", 32'(wr_beats - b0), 32'd0);
        rd(32'h404, 1'b0, "R9");
        issue(2'd2, 32'h3C04, 32'd0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b1, "R9");
        // R5 random mode, only way 0 unlocked
        repl_random = 1'b1;
        lock_mask = 4'b1110;
        rd(32'h3000, 1'b0, "R5");
        rd(32'h3400, 1'b0, "R5");
        rd(32'h3800, 1'b0, "R5");
        rd(32'h1C00, 1'b1, "R5");
        rd(32'h2400, 1'b1, "R5");
        // random mode unlocked: data integrity on set 1
        lock_mask = 4'b0000;
        for (int k = 0; k < 12; k++) begin
            logic [31:0] a;
            a = 32'h020 + 32'(k % 6) * 32'h400 + 32'(k % 8) * 4;
            issue(2'd0, a, 32'd0, 1'b0, bmem[a[13:2]], 1'b0, 1'b1, 1'b0, "R1");
        end
        // R1 fill order: line words read back from a fresh line
        repl_random = 1'b0;
        rd(32'h0E0, 1'b0, "R1");
        for (int k = 0; k < 8; k++) rd(32'h0E0 + 32'(k * 4), 1'b1, "R1");

        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule